// File: doc/BRIEF.md
# Non-Volatile Settings Write Scheduler

This block decides when a settings store that wears out with use must be written. It watches command strobes for latched values and for configuration settings, a low-power configuration strobe, a low-power cycle pulse, the unit status code and a one-second tick. From these it issues single-cycle write requests. Each request carries a reason code. Commands that carry settings cause a write only when the new value differs from the stored one. Automatic saves happen at four points: a fixed delay after lock is reached, every long period spent in lock, an alarm-driven reset out of lock, and each low-power cycle.

All triggers seen in one cycle merge into a single request, which is tagged with the reason of highest priority. A saturating counter tracks how many writes have been issued. When the counter reaches the endurance limit, a sticky flag rises and every later request is withheld. This protects the store from writes past its rated endurance. The memory itself and the parsing of commands are outside the block.

Top module: `nvram_wr_ctrl`

## Requirements
- R1: After reset, `wr_req_o` is 0, `wr_reason_o` is 0 and `budget_out_o` is 0.
- R2: A pulse on `freq_latch_i` or on `cable_latch_i` produces exactly one request, one cycle later, with reason code 1.
- R3: A strobe on `set_wr_i[i]` produces a request with reason 2 only when slice i of `set_old_i` differs from slice i of `set_new_i`. Each slice is VW bits wide and slice i occupies bits [i*VW +: VW]. A strobe whose old and new slices are equal produces no request.
- R4: A pulse on `ulp_cfg_i` produces a request with reason 3. A pulse on `ulp_cycle_i` produces a request with reason 4.
- R5: Status code 0 means locked. When `status_i` is 0 in one cycle and 8 in the next, a request with reason 5 follows. A move from 0 to any other code produces no request.
- R6: On entry into lock, a save timer starts. The SAVE_DELAY-th tick received while the unit stays locked produces a request with reason 6. A tick that arrives in the cycle of lock entry is not counted. Leaving lock before that tick cancels the timer, and the next lock entry restarts it from zero.
- R7: While the unit is locked, every PERIOD-th tick produces a request with reason 7. The tick count starts with the cycle of lock entry and is cleared whenever the unit is not locked.
- R8: Triggers that occur in the same cycle produce one request in the next cycle. Its reason is the highest-priority trigger present. The priority order, from highest to lowest, is 1, 2, 3, 4, 5, 6, 7. When there is no request, the reason code is 0.
- R9: Every request issued increments a counter that saturates at WR_LIMIT. `budget_out_o` rises together with the WR_LIMIT-th request and then stays high. While it is high, no further request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_latch_i | input | 1 | Frequency latch command strobe |
| cable_latch_i | input | 1 | Cable-delay compensation latch strobe |
| set_wr_i | input | NSET | Per-setting write strobes |
| set_old_i | input | NSET*VW | Stored values, slice i = setting i |
| set_new_i | input | NSET*VW | Requested values, slice i = setting i |
| ulp_cfg_i | input | 1 | Low-power schedule configuration strobe |
| ulp_cycle_i | input | 1 | Pulse once per low-power cycle |
| status_i | input | 4 | Unit status code, 0 = locked |
| tick_1s_i | input | 1 | One-second tick pulse |
| wr_req_o | output | 1 | Single-cycle write request |
| wr_reason_o | output | 3 | Reason code of the request |
| budget_out_o | output | 1 | Sticky flag: write budget used up |

## Verification
A command latch and the expiry of the post-lock save timer can fall in the same cycle. The bench provokes this by pulsing the cable latch strobe together with the SAVE_DELAY-th tick after lock entry. It expects exactly one request with reason 1, and no request in the following cycle, because the timed save has been absorbed into that write. The bench also pulses the frequency latch, the low-power cycle pulse and a changed setting together, and judges the single merged request by its priority-encoded reason.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    localparam logic [3:0] ST_LOCKED      = 4'd0;
    localparam logic [3:0] ST_ALARM_RESET = 4'd8;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_LATCH    = 3'd1,
        RSN_SETTING  = 3'd2,
        RSN_ULP_CFG  = 3'd3,
        RSN_ULP_CYC  = 3'd4,
        RSN_LOSS     = 3'd5,
        RSN_POSTLOCK = 3'd6,
        RSN_PERIODIC = 3'd7
    } reason_e;

    typedef struct packed {
        logic latch;
        logic setting;
        logic ulp_cfg;
        logic ulp_cyc;
        logic loss;
        logic postlock;
        logic periodic;
    } trig_t;

    function automatic logic trig_any(input trig_t t);
        return |t;
    endfunction

    function automatic reason_e pick_reason(input trig_t t);
        reason_e r;
        if (t.latch)         r = RSN_LATCH;
        else if (t.setting)  r = RSN_SETTING;
        else if (t.ulp_cfg)  r = RSN_ULP_CFG;
        else if (t.ulp_cyc)  r = RSN_ULP_CYC;
        else if (t.loss)     r = RSN_LOSS;
        else if (t.postlock) r = RSN_POSTLOCK;
        else if (t.periodic) r = RSN_PERIODIC;
        else                 r = RSN_NONE;
        return r;
    endfunction

endpackage

// File: rtl/nvw_change_det.sv
module nvw_change_det #(
    parameter int NSET = 4,
    parameter int VW   = 16
) (
    input  logic [NSET-1:0]    wr_i,
    input  logic [NSET*VW-1:0] old_i,
    input  logic [NSET*VW-1:0] new_i,
    output logic               changed_o
);
    logic [NSET-1:0] diff;

    genvar g;
    generate
        for (g = 0; g < NSET; g++) begin : g_slot
            assign diff[g] = wr_i[g] && (old_i[g*VW +: VW] != new_i[g*VW +: VW]);
        end
    endgenerate

    assign changed_o = |diff;
endmodule

// File: rtl/nvw_lock_timers.sv
module nvw_lock_timers
    import nvw_pkg::*;
#(
    parameter int SAVE_DELAY = 102,
    parameter int PERIOD     = 2592000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] status_i,
    input  logic       tick_i,
    output logic       loss_evt_o,
    output logic       post_evt_o,
    output logic       per_evt_o
);
    localparam int DW = $clog2(SAVE_DELAY + 1);
    localparam int QW = $clog2(PERIOD + 1);
    localparam logic [DW-1:0] D_LAST = DW'(SAVE_DELAY - 1);
    localparam logic [QW-1:0] Q_LAST = QW'(PERIOD - 1);

    logic [3:0]    prev_st;
    logic          armed;
    logic [DW-1:0] dcnt;
    logic [QW-1:0] qcnt;
    logic          lock_now;
    logic          lock_entry;

    assign lock_now   = (status_i == ST_LOCKED);
    assign lock_entry = lock_now && (prev_st != ST_LOCKED);
    assign loss_evt_o = (prev_st == ST_LOCKED) && (status_i == ST_ALARM_RESET);
    assign post_evt_o = armed && lock_now && tick_i && (dcnt == D_LAST);
    assign per_evt_o  = lock_now && tick_i && (qcnt == Q_LAST);

    always_ff @(posedge clk) begin
        if (rst) prev_st <= 4'hF;
        else     prev_st <= status_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            dcnt  <= '0;
        end else if (!lock_now) begin
            armed <= 1'b0;
            dcnt  <= '0;
        end else if (lock_entry) begin
            armed <= 1'b1;
            dcnt  <= '0;
        end else if (armed && tick_i) begin
            if (dcnt == D_LAST) begin
                armed <= 1'b0;
                dcnt  <= '0;
            end else begin
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !lock_now) begin
            qcnt <= '0;
        end else if (tick_i) begin
            if (qcnt == Q_LAST) qcnt <= '0;
            else                qcnt <= qcnt + 1'b1;
        end
    end
endmodule

// File: rtl/nvw_arbiter.sv
module nvw_arbiter
    import nvw_pkg::*;
#(
    parameter int WR_LIMIT = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  trig_t      trig_i,
    output logic       req_o,
    output reason_e    reason_o,
    output logic       exhausted_o
);
    localparam int CW = $clog2(WR_LIMIT + 1);
    localparam logic [CW-1:0] C_LAST = CW'(WR_LIMIT - 1);

    logic [CW-1:0] wr_cnt;
    logic          issue;

    assign issue = trig_any(trig_i) && !exhausted_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_o       <= 1'b0;
            reason_o    <= RSN_NONE;
            wr_cnt      <= '0;
            exhausted_o <= 1'b0;
        end else begin
            req_o    <= issue;
            reason_o <= issue ? pick_reason(trig_i) : RSN_NONE;
            if (issue) begin
                wr_cnt <= wr_cnt + 1'b1;
                if (wr_cnt == C_LAST) exhausted_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvram_wr_ctrl.sv
module nvram_wr_ctrl
    import nvw_pkg::*;
#(
    parameter int NSET       = 4,
    parameter int VW         = 16,
    parameter int SAVE_DELAY = 102,
    parameter int PERIOD     = 2592000,
    parameter int WR_LIMIT   = 20000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               freq_latch_i,
    input  logic               cable_latch_i,
    input  logic [NSET-1:0]    set_wr_i,
    input  logic [NSET*VW-1:0] set_old_i,
    input  logic [NSET*VW-1:0] set_new_i,
    input  logic               ulp_cfg_i,
    input  logic               ulp_cycle_i,
    input  logic [3:0]         status_i,
    input  logic               tick_1s_i,
    output logic               wr_req_o,
    output logic [2:0]         wr_reason_o,
    output logic               budget_out_o
);
    trig_t   trig;
    reason_e reason;
    logic    changed, loss_evt, post_evt, per_evt;

    nvw_change_det #(.NSET(NSET), .VW(VW)) u_chg (
        .wr_i(set_wr_i), .old_i(set_old_i), .new_i(set_new_i), .changed_o(changed)
    );

    nvw_lock_timers #(.SAVE_DELAY(SAVE_DELAY), .PERIOD(PERIOD)) u_tmr (
        .clk(clk), .rst(rst), .status_i(status_i), .tick_i(tick_1s_i),
        .loss_evt_o(loss_evt), .post_evt_o(post_evt), .per_evt_o(per_evt)
    );

    always_comb begin
        trig.latch    = freq_latch_i | cable_latch_i;
        trig.setting  = changed;
        trig.ulp_cfg  = ulp_cfg_i;
        trig.ulp_cyc  = ulp_cycle_i;
        trig.loss     = loss_evt;
        trig.postlock = post_evt;
        trig.periodic = per_evt;
    end

    nvw_arbiter #(.WR_LIMIT(WR_LIMIT)) u_arb (
        .clk(clk), .rst(rst), .trig_i(trig),
        .req_o(wr_req_o), .reason_o(reason), .exhausted_o(budget_out_o)
    );

    assign wr_reason_o = reason;
endmodule

// File: rtl/nvram_wr_ctrl_chk.sv
module nvram_wr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       freq_latch_i,
    input logic [3:0] status_i,
    input logic       wr_req_o,
    input logic [2:0] wr_reason_o,
    input logic       budget_out_o
);
    // R8
    req_reason_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req_o == (wr_reason_o != 3'd0));

    // R2
    latch_req_chk: assert property (@(posedge clk) disable iff (rst)
        (freq_latch_i && !budget_out_o) |=> (wr_req_o && wr_reason_o == 3'd1));

    // R5
    alarm_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(status_i) == 4'd0 && status_i == 4'd8 && !budget_out_o)
        |=> wr_req_o);

    // R9
    budget_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        budget_out_o |=> budget_out_o);

    // R9
    budget_block_chk: assert property (@(posedge clk) disable iff (rst)
        budget_out_o |=> !wr_req_o);
endmodule

bind nvram_wr_ctrl nvram_wr_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .freq_latch_i(freq_latch_i), .status_i(status_i),
    .wr_req_o(wr_req_o), .wr_reason_o(wr_reason_o), .budget_out_o(budget_out_o)
);

// File: tb/test_nvram_wr_ctrl.sv
module test_nvram_wr_ctrl;
    localparam int NSET = 4, VW = 8, SD = 5, PER = 12, LIM = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic freq_latch = 0, cable_latch = 0, ulp_cfg = 0, ulp_cycle = 0, tick = 0;
    logic [NSET-1:0] set_wr = '0;
    logic [NSET*VW-1:0] set_old = '0, set_new = '0;
    logic [3:0] status = 4'd2;
    logic wr_req, budget;
    logic [2:0] reason;
    int checks = 0, fails = 0, seen = 0;
    logic r;
    logic [2:0] rs;

    always #10 clk = ~clk;

    nvram_wr_ctrl #(.NSET(NSET), .VW(VW), .SAVE_DELAY(SD), .PERIOD(PER), .WR_LIMIT(LIM)) i_nvram_wr_ctrl (
        .clk(clk), .rst(rst), .freq_latch_i(freq_latch), .cable_latch_i(cable_latch),
        .set_wr_i(set_wr), .set_old_i(set_old), .set_new_i(set_new),
        .ulp_cfg_i(ulp_cfg), .ulp_cycle_i(ulp_cycle), .status_i(status),
        .tick_1s_i(tick), .wr_req_o(wr_req), .wr_reason_o(reason), .budget_out_o(budget)
    );

    always @(negedge clk) if (!rst && wr_req) seen++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
        r = wr_req; rs = reason;
        freq_latch = 0; cable_latch = 0; ulp_cfg = 0; ulp_cycle = 0; tick = 0; set_wr = '0;
    endtask

    task automatic ticks_none(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            tick = 1; step();
            chk(tag, r, 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 req", wr_req, 0);
        chk("R1 reason", reason, 0);
        chk("R1 budget", budget, 0);
    endtask

    task automatic t_latch();
        freq_latch = 1; step();
        chk("R2 freq req", r, 1); chk("R2 freq reason", rs, 1);
        step(); chk("R2 single", r, 0);
        cable_latch = 1; step();
        chk("R2 cable req", r, 1); chk("R2 cable reason", rs, 1);
    endtask

    task automatic t_setting();
        set_old[1*VW +: VW] = 8'h55; set_new[1*VW +: VW] = 8'h55; set_wr = 4'b0010;
        step(); chk("R3 equal no req", r, 0);
        step(); chk("R3 equal still none", r, 0);
        set_new[1*VW +: VW] = 8'h56; set_wr = 4'b0010;
        step(); chk("R3 changed req", r, 1); chk("R3 reason", rs, 2);
        set_old[3*VW +: VW] = 8'h01; set_new[3*VW +: VW] = 8'h01; set_wr = 4'b0010 ^ 4'b0010 | 4'b1000;
        step(); chk("R3 other slot equal", r, 0);
    endtask

    task automatic t_ulp();
        ulp_cfg = 1; ulp_cycle = 1; step();
        chk("R8 cfg over cycle", rs, 3);
        ulp_cycle = 1; step();
        chk("R4 cycle req", r, 1); chk("R4 cycle reason", rs, 4);
        ulp_cfg = 1; step();
        chk("R4 cfg reason", rs, 3);
    endtask

    task automatic t_merge();
        freq_latch = 1; ulp_cycle = 1; set_wr = 4'b0010; step();
        chk("R8 merged req", r, 1); chk("R8 merged reason", rs, 1);
        step(); chk("R8 no second req", r, 0);
    endtask

    task automatic t_lock();
        status = 4'd0; tick = 1; step();
        chk("R6 entry no req", r, 0);
        ticks_none(SD - 1, "R6 before delay");
        tick = 1; step();
        chk("R6 post-lock req", r, 1); chk("R6 reason", rs, 6);
        ticks_none(PER - SD - 2, "R7 before period");
        tick = 1; step();
        chk("R7 periodic req", r, 1); chk("R7 reason", rs, 7);
        ticks_none(PER - 1, "R7 second window");
        tick = 1; step();
        chk("R7 second periodic", rs, 7);
        status = 4'd2; step();
        chk("R5 exit to other code", r, 0);
    endtask

    task automatic t_cancel();
        status = 4'd0; step();
        ticks_none(3, "R6 partial");
        status = 4'd2; step();
        ticks_none(SD + 1, "R6 cancelled");
        status = 4'd0; step();
        ticks_none(SD - 1, "R6 restart");
        tick = 1; cable_latch = 1; step();
        chk("R8 latch with post-lock req", r, 1); chk("R8 latch wins", rs, 1);
        step(); chk("R8 timed save absorbed", r, 0);
        status = 4'd2; step();
    endtask

    task automatic t_loss();
        status = 4'd0; step();
        status = 4'd8; step();
        chk("R5 loss req", r, 1); chk("R5 reason", rs, 5);
        status = 4'd0; step();
        status = 4'd3; step();
        chk("R5 other exit none", r, 0);
        status = 4'd8; step();
        chk("R5 8 without prior lock", r, 0);
        status = 4'd2; step();
    endtask

    task automatic t_budget();
        while (seen < LIM - 1) begin
            freq_latch = 1; step();
        end
        chk("R9 flag low before limit", budget, 0);
        freq_latch = 1; step();
        chk("R9 last req", r, 1); chk("R9 flag rises", budget, 1);
        freq_latch = 1; set_wr = 4'b0010; step();
        chk("R9 blocked", r, 0);
        ulp_cycle = 1; step(); step();
        chk("R9 still blocked", r, 0); chk("R9 sticky", budget, 1);
        chk("R9 total writes", seen, LIM);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        t_reset();
        t_latch();
        t_setting();
        t_ulp();
        t_merge();
        t_lock();
        t_cancel();
        t_loss();
        t_budget();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule